// File: doc/BRIEF.md
# Debug CPU Control Register Unit

This block is the control core of an on-chip debug port for a small 16-bit processor. An upstream serial link decodes host commands into simple register accesses (address, write strobe, read strobe, write data) and hands them to this unit. The unit holds a CPU control register and a memory data register, and from them drives a halt request to the CPU. It also decides whether the CPU comes out of power-on reset running or held in break.

Two reset sources are kept apart. The power-on reset clears the debug registers and also drives the CPU reset output. The debug-enable input passes through a two-flop reset synchroniser and acts only as the reset of the debug domain. Dropping it clears every debug register and releases any halt, and the CPU keeps running. The parameter `BRK_ON_RST` selects whether a CPU that leaves power-on reset with debug enabled is held halted.

Top module: `dbg_cpu_ctl`

## Requirements
- R1: While debug-enable is low, `cpu_halt_o` is 0, so the CPU runs after power-on reset when debug is disabled.
- R2: Raising debug-enable after power-on reset has completed, or after a debug-domain reset, leaves `cpu_halt_o` at 0.
- R3: If debug-enable is high across power-on reset, `cpu_halt_o` is 1 from the first clock after reset release when `BRK_ON_RST`=1, and stays 0 when `BRK_ON_RST`=0.
- R4: The control register is at address 0. Bit 0 is the halt bit (writable, reads back). Bit 1 is the run command and always reads 0. Bit 4 is a writable flag that resets to 1. Bit 5 is the break-arm bit, which resets to `BRK_ON_RST` and is writable. All other bits read 0. The reset value is therefore 0x0030 with break-on-reset and 0x0010 without it.
- R5: A control write with bit 0 set halts the CPU after that edge. A control write with bit 1 set and bit 0 clear releases it. A control write with both bits clear leaves the halt state unchanged. A write of 0x0000 reads back 0x0000.
- R6: The memory data register at address 1 stores any 16-bit write, reads it back, and resets to 0x0000.
- R7: Debug-enable held low for two clock cycles returns both registers to their reset values and drops the halt request, without asserting `cpu_rst_no`.
- R8: `rst_ni` low resets both registers, and it drives `cpu_rst_no` low at once. `cpu_rst_no` rises `SYNC_STAGES` clock edges after `rst_ni` is released.
- R9: Read data appears on `reg_rdata_o` after the clock edge that samples `reg_rd_i`, and it holds its value while no read is strobed.
- R10: Addresses 2 and 3 read as 0x0000, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| dbg_en_i | input | 1 | Debug enable; low resets the debug domain |
| reg_addr_i | input | AW | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Registered read data |
| cpu_halt_o | output | 1 | Halt request to the CPU |
| cpu_rst_no | output | 1 | CPU reset, active low |

## Verification
A write takes effect at the clock edge that samples the strobe, so the register contents and `cpu_halt_o` are checked at the falling edge that follows. Read data is registered once and is checked at the falling edge after the read strobe. A rising debug-enable or power-on reset needs `SYNC_STAGES` rising edges before the domain leaves reset, so the bench waits three falling edges before it issues any access. Both parameter settings run side by side on the same stimulus. The bench writes all 64 values of the low six control bits and computes the expected readback and halt state arithmetically from the previous state.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int unsigned ADDR_CTL  = 0;
  localparam int unsigned ADDR_MDAT = 1;
  localparam int unsigned CTL_HALT  = 0;
  localparam int unsigned CTL_RUN   = 1;
  localparam int unsigned CTL_AUX   = 4;
  localparam int unsigned CTL_ARM   = 5;
  localparam int unsigned CTL_MSB   = 5;
endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge arst_ni)
        if (!arst_ni) q <= '0;
        else          q <= 1'b1;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_ni)
        if (!arst_ni) q <= '0;
        else          q <= {q[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign rst_no = q[STAGES-1];

  AST_REL_AFTER_IN: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(rst_no) |-> $past(arst_ni)); // R8
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned AW         = 2,
  parameter bit          BRK_ON_RST = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          halt_wr_o,
  output logic          run_wr_o,
  output logic          brk_arm_o
);
  localparam logic [DW-1:0] CTL_MASK = DW'((1 << CTL_HALT) | (1 << CTL_AUX) | (1 << CTL_ARM));

  logic          halt_q, aux_q, arm_q;
  logic [DW-1:0] mdat_q, ctl_val, rd_mux, rdata_q;
  logic          wr_ctl, wr_mdat;

  assign wr_ctl  = wr_i && (addr_i == AW'(ADDR_CTL));
  assign wr_mdat = wr_i && (addr_i == AW'(ADDR_MDAT));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      halt_q <= 1'b0;
      aux_q  <= 1'b1;
      arm_q  <= BRK_ON_RST;
    end else if (wr_ctl) begin
      halt_q <= wdata_i[CTL_HALT];
      aux_q  <= wdata_i[CTL_AUX];
      arm_q  <= wdata_i[CTL_ARM];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      mdat_q <= '0;
    else if (wr_mdat) mdat_q <= wdata_i;

  always_comb begin
    ctl_val           = '0;
    ctl_val[CTL_HALT] = halt_q;
    ctl_val[CTL_AUX]  = aux_q;
    ctl_val[CTL_ARM]  = arm_q;
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == AW'(ADDR_CTL))       rd_mux = ctl_val;
    else if (addr_i == AW'(ADDR_MDAT)) rd_mux = mdat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;

  assign rdata_o   = rdata_q;
  assign halt_wr_o = wr_ctl && wdata_i[CTL_HALT];
  assign run_wr_o  = wr_ctl && wdata_i[CTL_RUN];
  assign brk_arm_o = arm_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(rd_i)) |-> $stable(rdata_o)); // R9
  AST_CTL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(ADDR_CTL)) |=> ((rdata_o & ~CTL_MASK) == '0)); // R4
  AST_MDAT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mdat |=> $stable(mdat_q)); // R10
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl (
  input  logic clk_i,
  input  logic por_ni,
  input  logic dbg_rst_ni,
  input  logic dbg_on_i,
  input  logic brk_arm_i,
  input  logic halt_wr_i,
  input  logic run_wr_i,
  output logic halted_o
);
  logic brk_pend_q, halted_q, brk_set;

  // one-shot window in the first cycle after power-on reset
  always_ff @(posedge clk_i or negedge por_ni)
    if (!por_ni) brk_pend_q <= 1'b1;
    else         brk_pend_q <= 1'b0;

  assign brk_set = brk_pend_q && dbg_on_i && brk_arm_i;

  always_ff @(posedge clk_i or negedge dbg_rst_ni)
    if (!dbg_rst_ni) halted_q <= 1'b0;
    else             halted_q <= halt_wr_i || brk_set || (halted_q && !run_wr_i);

  assign halted_o = halted_q;

  AST_RUN_CLEARS: assert property (@(posedge clk_i) disable iff (!por_ni)
    (run_wr_i && !halt_wr_i && !brk_pend_q) |=> !halted_q); // R5
  AST_HALT_SETS: assert property (@(posedge clk_i) disable iff (!por_ni)
    halt_wr_i |=> (halted_q || !dbg_rst_ni)); // R5
  AST_HALT_SRC: assert property (@(posedge clk_i) disable iff (!dbg_rst_ni)
    $rose(halted_q) |-> $past(halt_wr_i || brk_pend_q)); // R3
endmodule

// File: rtl/dbg_cpu_ctl.sv
module dbg_cpu_ctl #(
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          BRK_ON_RST  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dbg_en_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          cpu_halt_o,
  output logic          cpu_rst_no
);
  logic dbg_on, dbg_rst_n, halt_wr, run_wr, brk_arm;

  dbg_rst_sync #(.STAGES(SYNC_STAGES)) u_dbg_sync (
    .clk_i   (clk_i),
    .arst_ni (dbg_en_i),
    .rst_no  (dbg_on)
  );

  dbg_rst_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (cpu_rst_no)
  );

  assign dbg_rst_n = rst_ni && dbg_on;

  dbg_regs #(.DW(DW), .AW(AW), .BRK_ON_RST(BRK_ON_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (dbg_rst_n),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .halt_wr_o (halt_wr),
    .run_wr_o  (run_wr),
    .brk_arm_o (brk_arm)
  );

  dbg_halt_ctl u_halt (
    .clk_i      (clk_i),
    .por_ni     (rst_ni),
    .dbg_rst_ni (dbg_rst_n),
    .dbg_on_i   (dbg_on),
    .brk_arm_i  (brk_arm),
    .halt_wr_i  (halt_wr),
    .run_wr_i   (run_wr),
    .halted_o   (cpu_halt_o)
  );

  AST_HALT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_en_i |-> !cpu_halt_o); // R1
  AST_CPU_NOT_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dbg_en_i) |-> cpu_rst_no || !$past(cpu_rst_no)); // R7
endmodule

// File: tb/dbg_cpu_ctl_tb_top.sv
module dbg_cpu_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_en = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_b, rdata_n;
  logic        halt_b, halt_n, crst_b, crst_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dbg_cpu_ctl #(.BRK_ON_RST(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dbg_en_i(dbg_en), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata_b),
    .cpu_halt_o(halt_b), .cpu_rst_no(crst_b));

  dbg_cpu_ctl #(.BRK_ON_RST(1'b0)) dut_nb_i (
    .clk_i(clk), .rst_ni(rst_n), .dbg_en_i(dbg_en), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata_n),
    .cpu_halt_o(halt_n), .cpu_rst_no(crst_n));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic hb, hn;
    logic [15:0] held;
    // power-on reset, debug disabled
    cyc(4);
    chk("R8 cpu_rst in reset", {14'd0, crst_b, crst_n}, 16'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 cpu_rst after 1 edge", {14'd0, crst_b, crst_n}, 16'h0);
    @(posedge clk); #1;
    chk("R8 cpu_rst after 2 edges", {14'd0, crst_b, crst_n}, 16'h3);
    cyc(20);
    chk("R1 no halt when disabled", {14'd0, halt_b, halt_n}, 16'h0);
    // enable after reset
    dbg_en = 1'b1;
    cyc(20);
    chk("R2 enable after POR keeps running", {14'd0, halt_b, halt_n}, 16'h0);
    // POR with debug enabled
    rst_n = 1'b0;
    cyc(2);
    chk("R8 cpu_rst asserted by POR", {14'd0, crst_b, crst_n}, 16'h0);
    rst_n = 1'b1;
    cyc(1);
    chk("R3 break on reset, first cycle", {14'd0, halt_b, halt_n}, 16'h2);
    cyc(4);
    chk("R3 break on reset held", {14'd0, halt_b, halt_n}, 16'h2);
    rd_reg(2'd0);
    chk("R4 ctl reset, break config", rdata_b, 16'h0030);
    chk("R4 ctl reset, no-break config", rdata_n, 16'h0010);
    rd_reg(2'd1);
    chk("R6 mdat reset", rdata_b, 16'h0000);
    chk("R6 mdat reset nb", rdata_n, 16'h0000);
    // exhaustive sweep of the six low control bits
    hb = 1'b1; hn = 1'b0;
    for (int w = 0; w < 64; w++) begin
      wr_reg(2'd0, 16'(w));
      hb = w[0] | (hb & ~w[1]);
      hn = w[0] | (hn & ~w[1]);
      chk("R5 halt after ctl write", {14'd0, halt_b, halt_n}, {14'd0, hb, hn});
      rd_reg(2'd0);
      chk("R4 ctl readback", rdata_b, 16'(w) & 16'h0031);
      chk("R4 ctl readback nb", rdata_n, 16'(w) & 16'h0031);
    end
    wr_reg(2'd0, 16'h0002);
    chk("R5 run command releases", {14'd0, halt_b, halt_n}, 16'h0);
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd0);
    chk("R5 write zero reads zero", rdata_b, 16'h0000);
    // memory data patterns
    for (int i = 0; i < 16; i++) begin
      wr_reg(2'd1, 16'(1 << i));
      rd_reg(2'd1);
      chk("R6 mdat walking one", rdata_b, 16'(1 << i));
      wr_reg(2'd1, ~16'(1 << i));
      rd_reg(2'd1);
      chk("R6 mdat walking zero", rdata_n, ~16'(1 << i));
    end
    // unmapped addresses
    wr_reg(2'd0, 16'h0011);
    wr_reg(2'd1, 16'haa55);
    wr_reg(2'd2, 16'hffff);
    wr_reg(2'd3, 16'hffff);
    rd_reg(2'd2);
    chk("R10 addr 2 reads zero", rdata_b, 16'h0000);
    rd_reg(2'd3);
    chk("R10 addr 3 reads zero", rdata_n, 16'h0000);
    rd_reg(2'd0);
    chk("R10 ctl untouched", rdata_b, 16'h0011);
    rd_reg(2'd1);
    chk("R10 mdat untouched", rdata_b, 16'haa55);
    // read data holds without strobe
    held = rdata_b;
    addr = 2'd0;
    cyc(3);
    chk("R9 rdata holds idle", rdata_b, held);
    wr_reg(2'd1, 16'h1234);
    chk("R9 rdata holds over write", rdata_b, held);
    rd_reg(2'd1);
    chk("R9 rdata after strobe", rdata_b, 16'h1234);
    // debug-enable drop for two cycles
    wr_reg(2'd0, 16'h0001);
    wr_reg(2'd1, 16'haa55);
    chk("R5 halt set before drop", {14'd0, halt_b, halt_n}, 16'h3);
    dbg_en = 1'b0;
    cyc(2);
    chk("R7 halt released by drop", {14'd0, halt_b, halt_n}, 16'h0);
    chk("R7 cpu not reset by drop", {14'd0, crst_b, crst_n}, 16'h3);
    dbg_en = 1'b1;
    cyc(3);
    chk("R2 re-enable keeps running", {14'd0, halt_b, halt_n}, 16'h0);
    rd_reg(2'd0);
    chk("R7 ctl back to reset", rdata_b, 16'h0030);
    chk("R7 ctl back to reset nb", rdata_n, 16'h0010);
    rd_reg(2'd1);
    chk("R7 mdat back to reset", rdata_b, 16'h0000);
    // POR resets registers
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd1, 16'haa55);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
    chk("R8 cpu_rst released", {14'd0, crst_b, crst_n}, 16'h3);
    chk("R3 break after second POR", {14'd0, halt_b, halt_n}, 16'h2);
    rd_reg(2'd1);
    chk("R8 mdat cleared by POR", rdata_b, 16'h0000);
    rd_reg(2'd0);
    chk("R8 ctl cleared by POR", rdata_n, 16'h0010);
    finish_run();
  end
endmodule